// File: doc/BRIEF.md
# SPI Master Serial Engine with Selectable Transfer Modes

This block is the serial core of an SPI master. The host loads outgoing bytes into a small transmit queue and collects incoming bytes from a small receive queue through plain push and pop strobes. A configuration write sets a 2-bit transfer mode, a frame count and an SCLK divider. A start pulse then runs one transfer on the serial pins: SCLK, MOSI, MISO and a single active-low chip select.

Four transfer modes are provided. Full duplex sends every queued byte and stores the byte received at the same time. Transmit-only sends the queued bytes and discards what comes back. Receive-only clocks in a programmed number of bytes. The memory-read mode suits serial flash and EEPROM reads. It first sends all queued bytes as opcode and address, for example one opcode followed by the high and low address bytes, and captures nothing during that time. Once the transmit queue has drained, it keeps MOSI low and captures exactly the programmed count plus one bytes. Chip select stays low across that switch.

Top module: `spi_mode_master`

## Requirements
- R1: `cfg_mode` encodes 0 = full duplex, 1 = transmit only, 2 = receive only, 3 = memory read. A `cfg_we` pulse loads `cfg_mode`, `cfg_frames` and `cfg_half` only while `busy` is low. A write while `busy` is high changes nothing.
- R2: Frames are 8 bits, most significant bit first, in SPI mode 0. MOSI changes on the falling SCLK edge and MISO is sampled on the rising edge. SCLK stays high and stays low for `cfg_half`+1 clock cycles each.
- R3: In full duplex, each queued transmit byte is sent and the byte received at the same time is pushed to the receive queue. The transfer ends when the transmit queue is empty. In modes 0 and 1, a start while the transmit queue is empty is ignored.
- R4: In transmit-only mode the queued bytes are sent and nothing is written to the receive queue.
- R5: In receive-only mode, MOSI is held at 0 and exactly `cfg_frames`+1 bytes are captured. The transmit queue is left untouched.
- R6: In memory-read mode, every queued byte is sent first, extra bytes included, and nothing is captured while they go out. After that, MOSI is held at 0 and exactly `cfg_frames`+1 further bytes are captured.
- R7: `cs_n` falls with `busy`, before the first SCLK edge. It stays low for the whole transfer, including the switch from sending to capturing. It rises one half SCLK period after the last falling SCLK edge, and `busy` falls with it.
- R8: A byte that completes while the receive queue is full is dropped, and `ovf` is set. `ovf` stays set until the host pulses `ovf_clr`.
- R9: After reset, `busy` is 0, `cs_n` is 1, `sclk` is 0, `ovf` is 0, the receive queue is empty and the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load mode, frame count and divider (ignored while busy) |
| cfg_mode | input | 2 | Transfer mode |
| cfg_frames | input | NFR_W | Receive frame count minus one |
| cfg_half | input | DIV_W | SCLK half period minus one, in clock cycles |
| start | input | 1 | Start request pulse |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Transmit byte |
| rx_pop | input | 1 | Pop the head of the receive queue |
| ovf_clr | input | 1 | Clear the overflow flag |
| miso | input | 1 | Serial data in |
| tx_full | output | 1 | Transmit queue full |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Transfer in progress |
| ovf | output | 1 | Sticky receive overflow flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The capture-phase assertion takes for granted that the host pushes no transmit byte while a memory-read transfer is busy. A byte pushed then would extend the sending phase and break its link between a non-empty transmit queue and the absence of captures. The bench pushes every byte before it pulses start and touches the configuration during a transfer only once, on purpose. The divider and frame count stay small, so that every transfer and the overflow case finish quickly.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;
  localparam int FRAME_W = 8;
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_TXONLY = 2'd1,
    XM_RXONLY = 2'd2,
    XM_MEMRD  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    EG_IDLE,
    EG_LEAD,
    EG_SHIFT,
    EG_TAIL
  } eng_st_e;
endpackage

// File: rtl/smm_fifo.sv
module smm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rdata = mem[rptr_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0));
endmodule

// File: rtl/smm_tick.sv
module smm_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == half);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smm_engine.sv
module smm_engine
  import spi_mode_pkg::*;
#(
  parameter int NFR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [NFR_W-1:0]   nfr,
  input  logic               tick,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_rdata,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_wdata,
  output logic               run,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  input  logic               miso
);
  eng_st_e            st_q, st_d;
  logic               sclk_q, sclk_d, cs_q, cs_d, rxph_q, rxph_d;
  logic [BIT_W-1:0]   bitn_q, bitn_d;
  logic [FRAME_W-1:0] shtx_q, shtx_d, shrx_q, shrx_d;
  logic [NFR_W-1:0]   fcnt_q, fcnt_d;
  logic               capture;

  assign capture  = (mode == XM_DUPLEX) || (mode == XM_RXONLY) ||
                    ((mode == XM_MEMRD) && rxph_q);
  assign busy     = (st_q != EG_IDLE);
  assign run      = busy;
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign mosi     = rxph_q ? 1'b0 : shtx_q[FRAME_W-1];
  assign rx_wdata = shrx_q;

  always_comb begin
    st_d = st_q; sclk_d = sclk_q; cs_d = cs_q; rxph_d = rxph_q;
    bitn_d = bitn_q; shtx_d = shtx_q; shrx_d = shrx_q; fcnt_d = fcnt_q;
    tx_pop = 1'b0; rx_push = 1'b0;
    unique case (st_q)
      EG_IDLE: if (start) begin
        fcnt_d = '0;
        bitn_d = '0;
        if (mode == XM_RXONLY || (mode == XM_MEMRD && tx_empty)) begin
          st_d = EG_LEAD; cs_d = 1'b0; rxph_d = 1'b1; shtx_d = '0;
        end else if (!tx_empty) begin
          st_d = EG_LEAD; cs_d = 1'b0; rxph_d = 1'b0;
          shtx_d = tx_rdata; tx_pop = 1'b1;
        end
      end
      EG_LEAD: if (tick) begin
        st_d = EG_SHIFT; sclk_d = 1'b1;
        shrx_d = {shrx_q[FRAME_W-2:0], miso};
        bitn_d = bitn_q + 1'b1;
      end
      EG_SHIFT: if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          shrx_d = {shrx_q[FRAME_W-2:0], miso};
          bitn_d = bitn_q + 1'b1;
        end else begin
          sclk_d = 1'b0;
          if (bitn_q == BIT_W'(FRAME_W)) begin
            bitn_d  = '0;
            rx_push = capture;
            if (rxph_q) begin
              if (fcnt_q == nfr) st_d = EG_TAIL;
              else               fcnt_d = fcnt_q + 1'b1;
            end else if (!tx_empty) begin
              shtx_d = tx_rdata; tx_pop = 1'b1;
            end else if (mode == XM_MEMRD) begin
              rxph_d = 1'b1; shtx_d = '0;
            end else begin
              st_d = EG_TAIL;
            end
          end else begin
            shtx_d = {shtx_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
      EG_TAIL: if (tick) begin
        st_d = EG_IDLE; cs_d = 1'b1;
      end
      default: st_d = EG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EG_IDLE; sclk_q <= 1'b0; cs_q <= 1'b1; rxph_q <= 1'b0;
      bitn_q <= '0; shtx_q <= '0; shrx_q <= '0; fcnt_q <= '0;
    end else begin
      st_q <= st_d; sclk_q <= sclk_d; cs_q <= cs_d; rxph_q <= rxph_d;
      bitn_q <= bitn_d; shtx_q <= shtx_d; shrx_q <= shrx_d; fcnt_q <= fcnt_d;
    end
  end

  assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_q);
  assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> (!sclk_q && $past(st_q) == EG_TAIL));
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spi_mode_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int NFR_W    = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [NFR_W-1:0] cfg_frames,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             start,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  input  logic             rx_pop,
  input  logic             ovf_clr,
  input  logic             miso,
  output logic             tx_full,
  output logic [7:0]       rx_data,
  output logic             rx_empty,
  output logic             busy,
  output logic             ovf,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  logic [1:0]         rsync_q;
  logic               rst_q;
  logic [1:0]         mode_q, mode_d;
  logic [NFR_W-1:0]   nfr_q, nfr_d;
  logic [DIV_W-1:0]   half_q, half_d;
  logic               ovf_q, ovf_d;
  logic               tick, run, tx_pop, tx_empty, rx_push, rx_full;
  logic [FRAME_W-1:0] tx_rdata, rx_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  always_comb begin
    mode_d = mode_q; nfr_d = nfr_q; half_d = half_q;
    if (cfg_we && !busy) begin
      mode_d = cfg_mode; nfr_d = cfg_frames; half_d = cfg_half;
    end
    ovf_d = (ovf_q && !ovf_clr) || (rx_push && rx_full);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mode_q <= XM_DUPLEX; nfr_q <= '0; half_q <= '0; ovf_q <= 1'b0;
    end else begin
      mode_q <= mode_d; nfr_q <= nfr_d; half_q <= half_d; ovf_q <= ovf_d;
    end
  end
  assign ovf = ovf_q;

  smm_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q), .push(tx_push), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_rdata), .full(tx_full), .empty(tx_empty));

  smm_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty));

  smm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_q), .run(run), .half(half_q), .tick(tick));

  smm_engine #(.NFR_W(NFR_W)) u_eng (
    .clk(clk), .rst_n(rst_q), .start(start), .mode(mode_q), .nfr(nfr_q),
    .tick(tick), .tx_empty(tx_empty), .tx_rdata(tx_rdata), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .run(run), .busy(busy),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> ($stable(mode_q) && $stable(nfr_q) && $stable(half_q)));
  assert_rx_quiet_mosi_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q == XM_RXONLY && !cs_n) |-> !mosi);
  assert_no_capture_cmd_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q == XM_MEMRD && busy && !tx_empty) |-> !rx_push);
  assert_txonly_no_push_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q == XM_TXONLY) |-> !rx_push);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: tb/spi_mode_master_tb.sv
`timescale 1ns/1ps
module spi_mode_master_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 0, start = 0, tx_push = 0, rx_pop = 0, ovf_clr = 0;
  logic [1:0] cfg_mode = 0;
  logic [3:0] cfg_frames = 0, cfg_half = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic       miso, tx_full, rx_empty, busy, ovf, sclk, mosi, cs_n;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  spi_mode_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_frames(cfg_frames), .cfg_half(cfg_half), .start(start),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .ovf_clr(ovf_clr),
    .miso(miso), .tx_full(tx_full), .rx_data(rx_data), .rx_empty(rx_empty),
    .busy(busy), .ovf(ovf), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 90) & 255);
  endfunction
  function automatic logic [7:0] txb(int v, int i);
    return 8'((v * 16 + i * 7 + 48) & 255);
  endfunction

  // serial slave model
  int         scnt = 0, sbit = 0, hw = 0;
  bit         first = 0;
  time        trise = 0;
  logic [7:0] mcap = 0, cur;
  logic [7:0] mlog [32];
  always @* begin
    cur  = pat(scnt);
    miso = cs_n ? 1'b0 : cur[3'(7 - sbit)];
  end
  always @(negedge cs_n) begin scnt = 0; sbit = 0; first = 1; end
  always @(posedge sclk) begin
    trise = $time;
    mcap  = {mcap[6:0], mosi};
    sbit++;
    if (sbit == 8) begin
      if (scnt < 32) mlog[scnt] = mcap;
      scnt++; sbit = 0;
    end
  end
  always @(negedge sclk) if (first) begin hw = int'(($time - trise) / 10); first = 0; end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R7", "watchdog cycles", cyc, 150000);
      summary();
    end
  end

  task automatic cfg(int m, int f, int h);
    @(negedge clk); cfg_we = 1; cfg_mode = 2'(m); cfg_frames = 4'(f); cfg_half = 4'(h);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic go_wait();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic drain(int base, int n, string req);
    for (int i = 0; i < n; i++) begin
      chk(!rx_empty, req, "rx entry present", int'(rx_empty), 0);
      chk(rx_data == pat(base + i), req, "rx byte", int'(rx_data), int'(pat(base + i)));
      rx_pop = 1; @(negedge clk); rx_pop = 0;
    end
    chk(rx_empty, req, "rx empty after drain", int'(rx_empty), 1);
  endtask

  // vector: {mode[13:12], frames[11:8], ntx[7:4], half[3:0]}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 4'd0, 4'd2, 4'd0}, {2'd1, 4'd0, 4'd3, 4'd1},
    {2'd2, 4'd2, 4'd0, 4'd0}, {2'd3, 4'd1, 4'd3, 4'd2},
    {2'd3, 4'd3, 4'd1, 4'd0}, {2'd0, 4'd0, 4'd4, 4'd3},
    {2'd3, 4'd0, 4'd0, 4'd0}, {2'd2, 4'd0, 4'd0, 4'd1}};

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy, "R9", "busy", int'(busy), 0);
    chk(cs_n, "R9", "cs_n", int'(cs_n), 1);
    chk(!sclk, "R9", "sclk", int'(sclk), 0);
    chk(!ovf, "R9", "ovf", int'(ovf), 0);
    chk(rx_empty, "R9", "rx_empty", int'(rx_empty), 1);
    chk(!tx_full, "R9", "tx_full", int'(tx_full), 0);

    for (int v = 0; v < 8; v++) begin
      int m = int'(VEC[v][13:12]), f = int'(VEC[v][11:8]);
      int nt = int'(VEC[v][7:4]), h = int'(VEC[v][3:0]);
      int frames, rbase, rn;
      string tg;
      tg = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
      cfg(m, f, h);
      for (int i = 0; i < nt; i++) begin
        @(negedge clk); tx_push = 1; tx_data = txb(v, i);
      end
      @(negedge clk); tx_push = 0;
      go_wait();
      frames = (m == 2) ? f + 1 : (m == 3) ? nt + f + 1 : nt;
      rbase  = (m == 3) ? nt : 0;
      rn     = (m == 0) ? nt : (m == 1) ? 0 : f + 1;
      chk(scnt == frames, tg, "frame count", scnt, frames);
      for (int i = 0; i < frames; i++) begin
        logic [7:0] e;
        e = (m != 2 && i < nt) ? txb(v, i) : 8'h00;
        chk(mlog[i] == e, tg, "mosi byte", int'(mlog[i]), int'(e));
      end
      chk(hw == h + 1, "R2", "sclk high width", hw, h + 1);
      chk(cs_n && !busy, "R7", "released after transfer", int'(cs_n), 1);
      drain(rbase, rn, tg);
    end

    // R3: start with empty transmit queue in full duplex is ignored
    cfg(0, 0, 0);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(!busy && cs_n, "R3", "empty-queue start ignored", int'(busy), 0);

    // R1: configuration write during busy is ignored
    cfg(2, 1, 0);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    cfg_we = 1; cfg_mode = 2'd1; cfg_frames = 4'd5; cfg_half = 4'd3;
    @(negedge clk); cfg_we = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(scnt == 2, "R1", "frames despite busy write", scnt, 2);
    drain(0, 2, "R1");
    go_wait();
    chk(scnt == 2, "R1", "mode kept after busy write", scnt, 2);
    chk(hw == 1, "R1", "divider kept after busy write", hw, 1);
    drain(0, 2, "R1");

    // R8: overflow drops frames and sets sticky flag
    cfg(2, 9, 0);
    go_wait();
    chk(scnt == 10, "R8", "frames sent", scnt, 10);
    chk(ovf, "R8", "ovf set", int'(ovf), 1);
    drain(0, 8, "R8");
    chk(ovf, "R8", "ovf sticky", int'(ovf), 1);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    @(negedge clk);
    chk(!ovf, "R8", "ovf cleared", int'(ovf), 0);

    summary();
  end
endmodule